// File: doc/BRIEF.md
# Multiplexed Front-End Readout Sequencer

This block runs the readout of one cable of front-end electronics. An external trigger starts a programmable delay, counted in whole clock cycles. When the delay ends, a hold strobe freezes the analogue samples in the front-end chips. The sequencer then moves a shared analogue multiplexer through its channel positions. At each position it starts one conversion on a bank of serial ADCs that run in parallel. It shifts the previous conversion results out of every ADC while the new conversion is running, then sends the captured words on a valid/ready stream.

Each scan has one slot per multiplexer position and one extra flush slot, so 19 slots with the default 18 positions. In the flush slot the multiplexer stays on the last position, and a dummy conversion clocks out the final real result. Every time value comes from live configuration inputs: the hold delay, the settle time before a conversion start, the slot period and the serial clock half-period. A test mode sends the configuration values through the event stream instead of starting a scan. A trigger that arrives while the block is busy is dropped and raises a sticky overlap flag.

Top module: `fe_scan_seq`

## Requirements
- R1: When a trigger is accepted at clock edge E0, `hold_o` rises at edge E0+D, where D is `cfg_hold_dly_i` (6 bits). D of 0 behaves as 1. `busy_o` rises at E0.
- R2: In slot s the multiplexer select is s for s = 0 to 17 and stays at 17 in the flush slot 18. It changes only at the start of a slot and is stable while a conversion start is high.
- R3: Each scan issues exactly 19 conversion-start pulses on `adc_cnv_o`, each one cycle wide. The first pulse comes S+1 cycles after `hold_o` rises, where S is `cfg_settle_i`. With no stream back-pressure, consecutive pulses are exactly P cycles apart, where P is `cfg_period_i`, and `hold_o` stays high for 19·P cycles. This holds only if P ≥ S+32·H+10; back-pressure only lengthens slots.
- R4: In every slot after the first, the serial clock `adc_sclk_o` makes exactly 16 low-to-high transitions once the conversion start has ended. Each high phase and each low phase lasts H cycles, where H is `cfg_sclk_half_i` and 0 behaves as 1. Each ADC's data line is sampled on the rising transition, MSB first. A scan therefore makes 288 rising transitions.
- R5: A scan emits 108 words of 16 bits. Word n carries ADC n mod 6 for channel n div 6 (channel-major, then ADC 0 to 5). Channel c's result is the one clocked out in slot c+1.
- R6: `ev_last_o` is high only on the final word of a scan, or on the fourth word in test mode, and never without `ev_valid_o`.
- R7: While `ev_valid_o` is high and `ev_ready_i` is low, the data and last flag hold steady. No word is lost or repeated under back-pressure.
- R8: A trigger that arrives while `busy_o` is high is ignored: no second hold, no extra words. It sets `overlap_o`, which stays high until the next accepted trigger clears it. `hold_o` is never high without `busy_o`.
- R9: A trigger in test mode emits four words and nothing else: hold delay, settle time, period and serial half-period, each zero-extended to 16 bits, with last on the fourth. There is no hold strobe, no conversion start and no serial clock.
- R10: After reset, `hold_o`, `adc_cnv_o`, `adc_sclk_o`, `ev_valid_o`, `busy_o` and `overlap_o` are low and the multiplexer select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Trigger request, sampled on each clock edge |
| test_mode_i | input | 1 | When high, a trigger emits the configuration words instead of a scan |
| cfg_hold_dly_i | input | 6 | Trigger-to-hold delay in clock cycles |
| cfg_settle_i | input | 10 | Cycles from slot start to the conversion start |
| cfg_period_i | input | 10 | Minimum slot length in cycles |
| cfg_sclk_half_i | input | 4 | Serial clock half-period in cycles |
| hold_o | output | 1 | Hold/sample strobe to the front-end chips, high for the whole scan |
| mux_sel_o | output | 5 | Analogue multiplexer position |
| adc_cnv_o | output | 1 | Conversion start, shared by all ADCs |
| adc_sclk_o | output | 1 | Serial clock, shared by all ADCs |
| adc_sdo_i | input | 6 | Serial data, one line per ADC |
| ev_valid_o | output | 1 | Event word valid |
| ev_ready_i | input | 1 | Event word accepted by the consumer |
| ev_data_o | output | 16 | Event word |
| ev_last_o | output | 1 | Final word of the event |
| busy_o | output | 1 | A delay, scan or test readout is in progress |
| overlap_o | output | 1 | Sticky flag: a trigger was dropped while busy |

## Verification
The bench runs one scan for each of six configurations. These include delays of 0, 1 and 63, a half-period of 0, and random back-pressure. For each scan it measures the hold latency, the spacing of the conversion starts, the slot at which each channel is selected, and the length of the serial clock phases. A one-off error in the delay counter or in the slot boundary shows up as a wrong cycle count. A sequencer that reads the current conversion instead of the previous one emits the wrong channel's word. An emitter that advances without a handshake drops or repeats words under back-pressure. Triggers placed during the delay and in the middle of a scan must leave exactly one hold pulse and 108 words. A design that restarts the scan, or loses the overlap flag, fails those counts. Test mode must send exactly the four configuration words and touch none of the ADC lines.

// File: rtl/fe_scan_pkg.sv
package fe_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_SETTLE,
    ST_SHIFT,
    ST_EMIT,
    ST_GAP,
    ST_CFG
  } seq_st_e;

  localparam int CFG_WORDS = 4;
endpackage

// File: rtl/fe_scan_hold_timer.sv
module fe_scan_hold_timer #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             fire_o
);
  logic             run_q, run_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  // fires on the edge the count reaches one; a zero delay fires like one
  assign fire_o = run_q && (cnt_q <= DLY_W'(1));

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start_i) begin
      run_d = 1'b1;
      cnt_d = dly_i;
    end else if (fire_o) begin
      run_d = 1'b0;
    end else if (run_q) begin
      cnt_d = cnt_q - DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fe_scan_serial_rx.sv
module fe_scan_serial_rx #(
  parameter int N_ADC  = 6,
  parameter int WORD_W = 16,
  parameter int HALF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [N_ADC-1:0]  sdo_i,
  output logic              sclk_o,
  output logic              done_o,
  output logic [WORD_W-1:0] words_o [N_ADC]
);
  localparam int BIT_W = $clog2(WORD_W);

  logic              act_q, act_d;
  logic              sclk_q, sclk_d;
  logic [HALF_W-1:0] hcnt_q, hcnt_d;
  logic [BIT_W-1:0]  bcnt_q, bcnt_d;
  logic [HALF_W-1:0] heff;
  logic              tick, rise, fall;

  assign heff   = (half_i == '0) ? HALF_W'(1) : half_i;
  assign tick   = act_q && (hcnt_q == heff - HALF_W'(1));
  assign rise   = tick && !sclk_q;
  assign fall   = tick && sclk_q;
  assign done_o = fall && (bcnt_q == BIT_W'(WORD_W - 1));
  assign sclk_o = sclk_q;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    hcnt_d = hcnt_q;
    bcnt_d = bcnt_q;
    if (start_i) begin
      act_d  = 1'b1;
      sclk_d = 1'b0;
      hcnt_d = '0;
      bcnt_d = '0;
    end else if (act_q) begin
      hcnt_d = tick ? '0 : hcnt_q + HALF_W'(1);
      if (rise) sclk_d = 1'b1;
      if (fall) begin
        sclk_d = 1'b0;
        bcnt_d = bcnt_q + BIT_W'(1);
      end
      if (done_o) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      hcnt_q <= hcnt_d;
      bcnt_q <= bcnt_d;
    end
  end

  // one capture shift register per converter, MSB arrives first
  for (genvar a = 0; a < N_ADC; a++) begin : g_cap
    logic [WORD_W-1:0] cap_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cap_q <= '0;
      else if (rise) cap_q <= {cap_q[WORD_W-2:0], sdo_i[a]};
    end
    assign words_o[a] = cap_q;
  end
endmodule

// File: rtl/fe_scan_seq.sv
module fe_scan_seq #(
  parameter int N_ADC  = 6,
  parameter int N_POS  = 18,
  parameter int WORD_W = 16,
  parameter int DLY_W  = 6,
  parameter int TIM_W  = 10,
  parameter int HALF_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig_i,
  input  logic                       test_mode_i,
  input  logic [DLY_W-1:0]           cfg_hold_dly_i,
  input  logic [TIM_W-1:0]           cfg_settle_i,
  input  logic [TIM_W-1:0]           cfg_period_i,
  input  logic [HALF_W-1:0]          cfg_sclk_half_i,
  output logic                       hold_o,
  output logic [$clog2(N_POS)-1:0]   mux_sel_o,
  output logic                       adc_cnv_o,
  output logic                       adc_sclk_o,
  input  logic [N_ADC-1:0]           adc_sdo_i,
  output logic                       ev_valid_o,
  input  logic                       ev_ready_i,
  output logic [WORD_W-1:0]          ev_data_o,
  output logic                       ev_last_o,
  output logic                       busy_o,
  output logic                       overlap_o
);
  import fe_scan_pkg::*;

  localparam int SEL_W  = $clog2(N_POS);
  localparam int SLOT_W = $clog2(N_POS + 1);
  localparam int IDX_W  = $clog2((N_ADC > CFG_WORDS) ? N_ADC : CFG_WORDS);

  // reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  seq_st_e           state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_nxt;
  logic [TIM_W-1:0]  tcnt_q, tcnt_d;
  logic [SEL_W-1:0]  mux_q, mux_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic              cnv_q, cnv_d;
  logic              hold_q, hold_d;
  logic              ovl_q, ovl_d;
  logic              timer_start, timer_fire;
  logic              rx_start, rx_done;
  logic [WORD_W-1:0] rx_words [N_ADC];
  logic              scanning;

  fe_scan_hold_timer #(.DLY_W(DLY_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (timer_start),
    .dly_i   (cfg_hold_dly_i),
    .fire_o  (timer_fire)
  );

  fe_scan_serial_rx #(.N_ADC(N_ADC), .WORD_W(WORD_W), .HALF_W(HALF_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (rx_start),
    .half_i  (cfg_sclk_half_i),
    .sdo_i   (adc_sdo_i),
    .sclk_o  (adc_sclk_o),
    .done_o  (rx_done),
    .words_o (rx_words)
  );

  assign scanning = (state_q == ST_SETTLE) || (state_q == ST_SHIFT) ||
                    (state_q == ST_EMIT)   || (state_q == ST_GAP);
  assign slot_nxt = slot_q + SLOT_W'(1);
  // shifting starts on the edge that ends the conversion start pulse
  assign rx_start = (state_q == ST_SHIFT) && cnv_q;

  always_comb begin
    state_d     = state_q;
    slot_d      = slot_q;
    tcnt_d      = tcnt_q;
    mux_d       = mux_q;
    widx_d      = widx_q;
    hold_d      = hold_q;
    ovl_d       = ovl_q;
    cnv_d       = 1'b0;
    timer_start = 1'b0;
    if (scanning && (tcnt_q != '1)) tcnt_d = tcnt_q + TIM_W'(1);
    if (trig_i && (state_q != ST_IDLE)) ovl_d = 1'b1;
    case (state_q)
      ST_IDLE: if (trig_i) begin
        ovl_d  = 1'b0;
        widx_d = '0;
        if (test_mode_i) begin
          state_d = ST_CFG;
        end else begin
          state_d     = ST_DELAY;
          timer_start = 1'b1;
        end
      end
      ST_DELAY: if (timer_fire) begin
        hold_d  = 1'b1;
        slot_d  = '0;
        tcnt_d  = '0;
        mux_d   = '0;
        state_d = ST_SETTLE;
      end
      ST_SETTLE: if (tcnt_q >= cfg_settle_i) begin
        cnv_d   = 1'b1;
        state_d = (slot_q == '0) ? ST_GAP : ST_SHIFT;
      end
      ST_SHIFT: if (rx_done) begin
        widx_d  = '0;
        state_d = ST_EMIT;
      end
      ST_EMIT: if (ev_ready_i) begin
        if (widx_q == IDX_W'(N_ADC - 1)) state_d = ST_GAP;
        else                             widx_d = widx_q + IDX_W'(1);
      end
      ST_GAP: if (({1'b0, tcnt_q} + (TIM_W+1)'(1)) >= {1'b0, cfg_period_i}) begin
        if (slot_q == SLOT_W'(N_POS)) begin
          hold_d  = 1'b0;
          state_d = ST_IDLE;
        end else begin
          slot_d  = slot_nxt;
          tcnt_d  = '0;
          mux_d   = (slot_nxt >= SLOT_W'(N_POS)) ? SEL_W'(N_POS - 1) : SEL_W'(slot_nxt);
          state_d = ST_SETTLE;
        end
      end
      ST_CFG: if (ev_ready_i) begin
        if (widx_q == IDX_W'(CFG_WORDS - 1)) state_d = ST_IDLE;
        else                                 widx_d = widx_q + IDX_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      tcnt_q  <= '0;
      mux_q   <= '0;
      widx_q  <= '0;
      cnv_q   <= 1'b0;
      hold_q  <= 1'b0;
      ovl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      tcnt_q  <= tcnt_d;
      mux_q   <= mux_d;
      widx_q  <= widx_d;
      cnv_q   <= cnv_d;
      hold_q  <= hold_d;
      ovl_q   <= ovl_d;
    end
  end

  always_comb begin
    ev_data_o = '0;
    if (state_q == ST_EMIT) begin
      ev_data_o = rx_words[widx_q];
    end else if (state_q == ST_CFG) begin
      case (widx_q)
        IDX_W'(0): ev_data_o = WORD_W'(cfg_hold_dly_i);
        IDX_W'(1): ev_data_o = WORD_W'(cfg_settle_i);
        IDX_W'(2): ev_data_o = WORD_W'(cfg_period_i);
        default:   ev_data_o = WORD_W'(cfg_sclk_half_i);
      endcase
    end
  end

  assign ev_valid_o = (state_q == ST_EMIT) || (state_q == ST_CFG);
  assign ev_last_o  = ((state_q == ST_EMIT) && (slot_q == SLOT_W'(N_POS)) &&
                       (widx_q == IDX_W'(N_ADC - 1))) ||
                      ((state_q == ST_CFG) && (widx_q == IDX_W'(CFG_WORDS - 1)));
  assign hold_o     = hold_q;
  assign mux_sel_o  = mux_q;
  assign adc_cnv_o  = cnv_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign overlap_o  = ovl_q;
endmodule

// File: rtl/fe_scan_seq_chk.sv
module fe_scan_seq_chk #(
  parameter int N_POS  = 18,
  parameter int WORD_W = 16,
  parameter int SEL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic [SEL_W-1:0]  mux,
  input logic              cnv,
  input logic              sclk,
  input logic              valid,
  input logic              ready,
  input logic [WORD_W-1:0] data,
  input logic              last,
  input logic              busy
);
  a_r3_cnv_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cnv |=> !cnv);

  a_r2_mux_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mux < SEL_W'(N_POS));

  a_r2_mux_settled: assert property (@(posedge clk) disable iff (!rst_n)
    cnv |-> $stable(mux));

  a_r4_sclk_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> hold);

  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data) && $stable(last)));

  a_r8_hold_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> busy);
endmodule

bind fe_scan_seq fe_scan_seq_chk #(.N_POS(N_POS), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .hold  (hold_o),
  .mux   (mux_sel_o),
  .cnv   (adc_cnv_o),
  .sclk  (adc_sclk_o),
  .valid (ev_valid_o),
  .ready (ev_ready_i),
  .data  (ev_data_o),
  .last  (ev_last_o),
  .busy  (busy_o)
);

// File: tb/fe_scan_seq_tb.sv
module fe_scan_seq_tb;
  localparam int N_ADC = 6;
  localparam int N_POS = 18;
  localparam int NWORD = N_ADC * N_POS;

  // {delay, settle, period, half, backpressure, expected hold latency}
  localparam int VEC [6][6] = '{
    '{18,  4, 200, 2, 0, 18},
    '{ 0,  3, 120, 1, 0,  1},
    '{ 1,  2, 150, 3, 1,  1},
    '{63, 10, 100, 1, 1, 63},
    '{ 5,  0,  90, 0, 0,  5},
    '{31, 20, 220, 4, 1, 31}
  };

  logic        clk, rst_n, trig, test_mode, ready;
  logic [5:0]  cfg_dly;
  logic [9:0]  cfg_settle, cfg_period;
  logic [3:0]  cfg_half;
  logic        hold_o, adc_cnv_o, adc_sclk_o, ev_valid_o, ev_last_o, busy_o, overlap_o;
  logic [4:0]  mux_sel_o;
  logic [5:0]  adc_sdo;
  logic [15:0] ev_data_o;

  int n_chk, n_fail, cyc, seed, rdy_mode;
  logic [7:0] lfsr;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  fe_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .test_mode_i(test_mode),
    .cfg_hold_dly_i(cfg_dly), .cfg_settle_i(cfg_settle), .cfg_period_i(cfg_period),
    .cfg_sclk_half_i(cfg_half), .hold_o(hold_o), .mux_sel_o(mux_sel_o),
    .adc_cnv_o(adc_cnv_o), .adc_sclk_o(adc_sclk_o), .adc_sdo_i(adc_sdo),
    .ev_valid_o(ev_valid_o), .ev_ready_i(ready), .ev_data_o(ev_data_o),
    .ev_last_o(ev_last_o), .busy_o(busy_o), .overlap_o(overlap_o)
  );

  function automatic logic [15:0] smp(int a, int ch, int sd);
    return 16'((a * 4369) ^ (ch * 2615) ^ (sd * 40503));
  endfunction

  // converter model: a start returns the previous result, stores the new one
  logic [15:0] stored [N_ADC];
  logic [15:0] shreg  [N_ADC];
  always @(posedge clk) begin
    if (rst_n && adc_cnv_o) begin
      for (int a = 0; a < N_ADC; a++) begin
        shreg[a]  <= stored[a];
        stored[a] <= smp(a, int'(mux_sel_o), seed);
      end
    end
  end
  always @(negedge adc_sclk_o) begin
    if (rst_n) for (int a = 0; a < N_ADC; a++) shreg[a] <= shreg[a] << 1;
  end
  always_comb for (int a = 0; a < N_ADC; a++) adc_sdo[a] = shreg[a][15];

  // monitor state
  int words_n, bad_n, last_n, last_at, cnv_n, cnv_prev, gap_min, gap_max, first_cnv;
  int busy_rise, hold_rise, hold_fall, hold_rises, mux_bad, sclk_rises, sclk_bad, hi_run;
  int cfgw [4];
  logic busy_p, hold_p, sclk_p;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int heff;
    cyc++;
    heff = (cfg_half == 0) ? 1 : int'(cfg_half);
    if (rdy_mode != 0) begin
      lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ready = lfsr[0] | lfsr[2];
    end else begin
      ready = 1'b1;
    end
    if (busy_o && !busy_p) busy_rise = cyc;
    if (hold_o && !hold_p) begin hold_rise = cyc; hold_rises++; end
    if (!hold_o && hold_p) hold_fall = cyc;
    if (adc_cnv_o) begin
      if (cnv_n == 0) first_cnv = cyc;
      else begin
        if (cyc - cnv_prev < gap_min) gap_min = cyc - cnv_prev;
        if (cyc - cnv_prev > gap_max) gap_max = cyc - cnv_prev;
      end
      if (int'(mux_sel_o) != ((cnv_n < N_POS) ? cnv_n : N_POS - 1)) mux_bad++;
      cnv_prev = cyc;
      cnv_n++;
    end
    if (adc_sclk_o && !sclk_p) sclk_rises++;
    if (adc_sclk_o) hi_run++;
    else if (sclk_p) begin
      if (hi_run != heff) sclk_bad++;
      hi_run = 0;
    end
    if (ev_valid_o && ready) begin
      if (test_mode) begin
        if (words_n < 4) cfgw[words_n] = int'(ev_data_o);
      end else if (ev_data_o != smp(words_n % N_ADC, words_n / N_ADC, seed)) begin
        bad_n++;
      end
      if (ev_last_o) begin last_n++; last_at = words_n; end
      words_n++;
    end
    busy_p = busy_o;
    hold_p = hold_o;
    sclk_p = adc_sclk_o;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic clear_mon();
    words_n = 0; bad_n = 0; last_n = 0; last_at = -1; cnv_n = 0; cnv_prev = 0;
    gap_min = 1 << 30; gap_max = 0; first_cnv = 0; busy_rise = 0; hold_rise = 0;
    hold_fall = 0; hold_rises = 0; mux_bad = 0; sclk_rises = 0; sclk_bad = 0; hi_run = 0;
    for (int i = 0; i < 4; i++) cfgw[i] = -1;
    seed++;
  endtask

  task automatic do_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; seed = 0; rdy_mode = 0; lfsr = 8'h5b;
    rst_n = 1'b0; trig = 1'b0; test_mode = 1'b0; ready = 1'b1;
    cfg_dly = 6'd3; cfg_settle = 10'd2; cfg_period = 10'd100; cfg_half = 4'd1;
    busy_p = 1'b0; hold_p = 1'b0; sclk_p = 1'b0;
    clear_mon();
    repeat (3) @(negedge clk);
    // R10: state held in reset
    chk(!hold_o && !adc_cnv_o && !adc_sclk_o && !ev_valid_o && !busy_o && !overlap_o,
        "R10 outputs in reset", int'(hold_o | adc_cnv_o | ev_valid_o | busy_o), 0);
    chk(mux_sel_o == 0, "R10 mux in reset", int'(mux_sel_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !ev_valid_o && !hold_o, "R10 idle after release", int'(busy_o), 0);

    // table-driven scans
    for (int v = 0; v < 6; v++) begin
      cfg_dly    = 6'(VEC[v][0]);
      cfg_settle = 10'(VEC[v][1]);
      cfg_period = 10'(VEC[v][2]);
      cfg_half   = 4'(VEC[v][3]);
      rdy_mode   = VEC[v][4];
      clear_mon();
      do_trig();
      wait_idle();
      chk(hold_rise - busy_rise == VEC[v][5], "R1 hold latency", hold_rise - busy_rise, VEC[v][5]);
      chk(hold_rises == 1, "R1 single hold", hold_rises, 1);
      chk(mux_bad == 0, "R2 mux at conversion", mux_bad, 0);
      chk(cnv_n == N_POS + 1, "R3 conversion count", cnv_n, N_POS + 1);
      chk(first_cnv - hold_rise == VEC[v][1] + 1, "R3 first conversion offset",
          first_cnv - hold_rise, VEC[v][1] + 1);
      if (rdy_mode == 0) begin
        chk(gap_min == VEC[v][2] && gap_max == VEC[v][2], "R3 conversion spacing",
            gap_max, VEC[v][2]);
        chk(hold_fall - hold_rise == (N_POS + 1) * VEC[v][2], "R3 hold width",
            hold_fall - hold_rise, (N_POS + 1) * VEC[v][2]);
      end else begin
        chk(gap_min >= VEC[v][2], "R3 R7 spacing under stall", gap_min, VEC[v][2]);
      end
      chk(sclk_rises == N_POS * 16, "R4 serial clock rises", sclk_rises, N_POS * 16);
      chk(sclk_bad == 0, "R4 serial clock high phase", sclk_bad, 0);
      chk(words_n == NWORD, "R5 R7 word count", words_n, NWORD);
      chk(bad_n == 0, "R5 R7 word values", bad_n, 0);
      chk(last_n == 1 && last_at == NWORD - 1, "R6 last position", last_at, NWORD - 1);
    end

    // R8: triggers during the delay and mid-scan are dropped
    rdy_mode = 0; cfg_dly = 6'd20; cfg_settle = 10'd3; cfg_period = 10'd100; cfg_half = 4'd1;
    clear_mon();
    do_trig();
    repeat (5) @(negedge clk);
    do_trig();
    repeat (300) @(negedge clk);
    do_trig();
    wait_idle();
    chk(overlap_o == 1'b1, "R8 overlap flag set", int'(overlap_o), 1);
    chk(hold_rises == 1, "R8 no second hold", hold_rises, 1);
    chk(words_n == NWORD && bad_n == 0, "R8 no extra words", words_n, NWORD);
    clear_mon();
    do_trig();
    chk(overlap_o == 1'b0, "R8 overlap cleared by new trigger", int'(overlap_o), 0);
    wait_idle();
    chk(words_n == NWORD && bad_n == 0, "R5 scan after overlap", bad_n, 0);

    // R9: test mode returns configuration words
    test_mode = 1'b1; rdy_mode = 1;
    cfg_dly = 6'd9; cfg_settle = 10'd7; cfg_period = 10'd300; cfg_half = 4'd5;
    clear_mon();
    do_trig();
    wait_idle();
    chk(words_n == 4, "R9 test word count", words_n, 4);
    chk(cfgw[0] == 9 && cfgw[1] == 7, "R9 delay and settle words", cfgw[1], 7);
    chk(cfgw[2] == 300 && cfgw[3] == 5, "R9 period and half words", cfgw[2], 300);
    chk(last_n == 1 && last_at == 3, "R6 R9 test last", last_at, 3);
    chk(cnv_n == 0 && hold_rises == 0 && sclk_rises == 0, "R9 converters untouched",
        cnv_n + hold_rises + sclk_rises, 0);
    test_mode = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule